// File: doc/BRIEF.md
# Twelve-Line GPIO Controller with Latched Level Interrupts

This block is a small memory-mapped general-purpose I/O controller. Software drives pads through an output data register and an output-enable register, and reads back the pad levels through an input register. Pad inputs pass through a two-stage synchroniser before anything inside the block uses them.

Each line has a level detector whose active sense (high or low) is chosen by one polarity bit per line. The polarity bits sit in two configuration words, one bit per 4-bit group. When a line is at its active level, its status bit latches. Software clears a status bit by writing a one to it. The status bits are ANDed with an enable mask and ORed together into one interrupt output. Because the detection is by level, a line whose source is still active when its bit is cleared latches again straight away. A separate 32-bit configuration word is stored and presented unchanged on an output port for external pad multiplexing.

The register port is a plain synchronous bus. A write takes one cycle with a write strobe. Read data is a combinational function of the address.

Top module: `gpio_lvl_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_o`, `pad_oe`, `mux_sel` are 0 and `irq` is low.
- R2: Offset 0x00 (output data) and offset 0x04 (output enable) are read/write on bits 11:0. `pad_oe` equals the enable register, and `pad_o` bit n equals data bit n only while enable bit n is 1 (else 0).
- R3: Offset 0x08 reads the pin levels after two clock edges of synchronisation, whatever the enable setting. Writes to 0x08 are ignored.
- R4: Polarity of line n is stored at bit 4*(n mod 8) of offset 0x10 (lines 0–7) or offset 0x18 (lines 8–11). A value of 0 means active-high and 1 means active-low. All other bits of these words read 0.
- R5: Offset 0x0C status bit n sets on the clock edge after the synchronised level of line n is at its active value. It stays set after the source goes inactive.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If a line is still active when its status bit is cleared, the bit reads 0 in the cycle after the write and 1 again one cycle later.
- R8: `irq` is high exactly when some status bit and its enable bit at offset 0x14 are both 1. An enable value of 0 holds `irq` low while status stays latched.
- R9: Offset 0x1C is a full 32-bit read/write word whose value drives `mux_sel`.
- R10: Bits 31:12 of the data, enable, status and interrupt-enable words read 0 and ignore writes. Addresses that match no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pin_in | input | 12 | Asynchronous pad input levels |
| pad_o | output | 12 | Pad output data, gated by enable |
| pad_oe | output | 12 | Pad output enables |
| mux_sel | output | 32 | Stored pad-mux configuration word |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: twelve lines, a 32-bit data word, a 5-bit address and two synchroniser stages. With these values the second polarity word is only half used, so its unused groups can be checked to read 0. The status path is exactly three edges behind the pins, which lets the bench check the re-latch after a clear cycle by cycle.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
   localparam int unsigned REG_W = 32;
   localparam logic [4:0] OFS_DOUT = 5'h00;
   localparam logic [4:0] OFS_OE   = 5'h04;
   localparam logic [4:0] OFS_DIN  = 5'h08;
   localparam logic [4:0] OFS_STS  = 5'h0C;
   localparam logic [4:0] OFS_TYPL = 5'h10;
   localparam logic [4:0] OFS_IEN  = 5'h14;
   localparam logic [4:0] OFS_TYPH = 5'h18;
   localparam logic [4:0] OFS_MUX  = 5'h1C;
   localparam int unsigned LINES_PER_TYPE = 8;
   localparam int unsigned TYPE_STRIDE    = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            stage_q[s] <= (s == 0) ? async_i : stage_q[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_type_regs.sv
module gpio_type_regs
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned N_LINES = 12
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_lo,
   input  logic                              wr_hi,
   input  logic [LINES_PER_TYPE-1:0]         sel_bits,
   output logic [N_LINES-1:0]                pol,
   output logic [REG_W-1:0]                  rd_lo,
   output logic [REG_W-1:0]                  rd_hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol <= '0;
      end else begin
         for (int n = 0; n < int'(N_LINES); n++) begin
            if ((n < int'(LINES_PER_TYPE)) ? wr_lo : wr_hi) begin
               pol[n] <= sel_bits[n % LINES_PER_TYPE];
            end
         end
      end
   end

   always_comb begin
      rd_lo = '0;
      rd_hi = '0;
      for (int n = 0; n < int'(N_LINES); n++) begin
         if (n < int'(LINES_PER_TYPE)) begin
            rd_lo[TYPE_STRIDE * (n % LINES_PER_TYPE)] = pol[n];
         end else begin
            rd_hi[TYPE_STRIDE * (n % LINES_PER_TYPE)] = pol[n];
         end
      end
   end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int unsigned N_LINES = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] lvl,
   input  logic [N_LINES-1:0] pol,
   input  logic               clr_wr,
   input  logic [N_LINES-1:0] clr_mask,
   input  logic [N_LINES-1:0] en,
   output logic [N_LINES-1:0] sts,
   output logic               irq
);
   logic [N_LINES-1:0] active;
   logic [N_LINES-1:0] clr_vec;

   // pol = 1 inverts the sense, giving active-low detection
   assign active  = lvl ^ pol;
   assign clr_vec = clr_wr ? clr_mask : '0;

   // a clear in the same cycle wins; the level re-latches on the next edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts <= '0;
      end else begin
         sts <= (sts | active) & ~clr_vec;
      end
   end

   assign irq = |(sts & en);
endmodule

// File: rtl/gpio_lvl_irq_ctrl.sv
module gpio_lvl_irq_ctrl
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned N_LINES     = 12,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [N_LINES-1:0] pin_in,
   output logic [N_LINES-1:0] pad_o,
   output logic [N_LINES-1:0] pad_oe,
   output logic [31:0]        mux_sel,
   output logic               irq
);
   localparam int unsigned MAX_LINES = 2 * LINES_PER_TYPE;

   if (N_LINES < 1 || N_LINES > MAX_LINES) begin : g_bad_lines
      $error("gpio_lvl_irq_ctrl: N_LINES out of range");
   end
   if (ADDR_W != 5) begin : g_bad_addr
      $error("gpio_lvl_irq_ctrl: ADDR_W must be 5");
   end

   logic [N_LINES-1:0] dout_q, oe_q, en_q, lvl_sync, pol_vec, sts_vec;
   logic [REG_W-1:0]   mux_q, typ_lo_rd, typ_hi_rd;
   logic [LINES_PER_TYPE-1:0] typ_bits;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [4:0] ofs);
      return a == ofs;
   endfunction

   for (genvar k = 0; k < int'(LINES_PER_TYPE); k++) begin : g_typ_bits
      assign typ_bits[k] = bus_wdata[TYPE_STRIDE * k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         oe_q   <= '0;
         en_q   <= '0;
         mux_q  <= '0;
      end else if (bus_wr) begin
         if (hit(bus_addr, OFS_DOUT)) dout_q <= bus_wdata[N_LINES-1:0];
         if (hit(bus_addr, OFS_OE))   oe_q   <= bus_wdata[N_LINES-1:0];
         if (hit(bus_addr, OFS_IEN))  en_q   <= bus_wdata[N_LINES-1:0];
         if (hit(bus_addr, OFS_MUX))  mux_q  <= bus_wdata;
      end
   end

   gpio_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (lvl_sync)
   );

   gpio_type_regs #(.N_LINES(N_LINES)) u_type (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (bus_wr && hit(bus_addr, OFS_TYPL)),
      .wr_hi    (bus_wr && hit(bus_addr, OFS_TYPH)),
      .sel_bits (typ_bits),
      .pol      (pol_vec),
      .rd_lo    (typ_lo_rd),
      .rd_hi    (typ_hi_rd)
   );

   gpio_irq_unit #(.N_LINES(N_LINES)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_sync),
      .pol      (pol_vec),
      .clr_wr   (bus_wr && hit(bus_addr, OFS_STS)),
      .clr_mask (bus_wdata[N_LINES-1:0]),
      .en       (en_q),
      .sts      (sts_vec),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (1'b1)
         hit(bus_addr, OFS_DOUT): bus_rdata[N_LINES-1:0] = dout_q;
         hit(bus_addr, OFS_OE):   bus_rdata[N_LINES-1:0] = oe_q;
         hit(bus_addr, OFS_DIN):  bus_rdata[N_LINES-1:0] = lvl_sync;
         hit(bus_addr, OFS_STS):  bus_rdata[N_LINES-1:0] = sts_vec;
         hit(bus_addr, OFS_TYPL): bus_rdata = typ_lo_rd;
         hit(bus_addr, OFS_IEN):  bus_rdata[N_LINES-1:0] = en_q;
         hit(bus_addr, OFS_TYPH): bus_rdata = typ_hi_rd;
         hit(bus_addr, OFS_MUX):  bus_rdata = mux_q;
         default:                 bus_rdata = '0;
      endcase
   end

   assign pad_o   = dout_q & oe_q;
   assign pad_oe  = oe_q;
   assign mux_sel = mux_q;
endmodule

// File: rtl/gpio_lvl_irq_ctrl_chk.sv
module gpio_lvl_irq_ctrl_chk
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned N_LINES = 12,
   parameter int unsigned ADDR_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr,
   input logic [31:0]        bus_wdata,
   input logic [N_LINES-1:0] sts,
   input logic [N_LINES-1:0] en,
   input logic [N_LINES-1:0] pad_o,
   input logic [N_LINES-1:0] pad_oe,
   input logic [31:0]        mux_sel,
   input logic               irq
);
   // R6
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_STS) |=> ((sts & $past(bus_wdata[N_LINES-1:0])) == '0));

   // R5
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == OFS_STS) |=> ((~sts & $past(sts)) == '0));

   // R8
   mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

   // R2
   pad_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_o & ~pad_oe) == '0));

   // R9
   mux_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_MUX) |=> (mux_sel == $past(bus_wdata)));
endmodule

bind gpio_lvl_irq_ctrl gpio_lvl_irq_ctrl_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .sts       (sts_vec),
   .en        (en_q),
   .pad_o     (pad_o),
   .pad_oe    (pad_oe),
   .mux_sel   (mux_sel),
   .irq       (irq)
);

// File: tb/gpio_lvl_irq_ctrl_bench.sv
module gpio_lvl_irq_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NL-1:0] pin_in = '0;
   logic [NL-1:0] pad_o, pad_oe;
   logic [31:0]   mux_sel;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_lvl_irq_ctrl u_gpio_lvl_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_o(pad_o), .pad_oe(pad_oe), .mux_sel(mux_sel), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset();
      for (int a = 0; a < 32; a += 4) rd_chk("R1 reg after reset", 5'(a), 32'h0);
      chk("R1 pad_o", 32'(pad_o), 0);
      chk("R1 pad_oe", 32'(pad_oe), 0);
      chk("R1 mux_sel", mux_sel, 0);
      chk("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_outputs();
      wr(5'h00, 32'hFFFF_FFFF);
      rd_chk("R10 data upper bits", 5'h00, 32'h0000_0FFF);
      chk("R2 pad_o gated by oe=0", 32'(pad_o), 0);
      wr(5'h04, 32'h0000_00F0);
      rd_chk("R2 oe readback", 5'h04, 32'h0000_00F0);
      chk("R2 pad_oe", 32'(pad_oe), 32'h0F0);
      chk("R2 pad_o", 32'(pad_o), 32'h0F0);
      wr(5'h00, 32'h0000_0A50);
      chk("R2 pad_o pattern", 32'(pad_o), 32'h050);
   endtask

   task automatic t_input_latch();
      pin_in = 12'hA5C;
      cyc(1);
      rd_chk("R3 one edge not yet visible", 5'h08, 32'h0);
      cyc(1);
      rd_chk("R3 input after two edges", 5'h08, 32'hA5C);
      wr(5'h08, 32'h0000_0123);
      rd_chk("R3 input write ignored", 5'h08, 32'hA5C);
      pin_in = '0;
      cyc(3);
      rd_chk("R5 status stays latched", 5'h0C, 32'hA5C);
      wr(5'h0C, 32'hFFFF_FFFF);
      rd_chk("R6 clear all", 5'h0C, 32'h0);
   endtask

   task automatic t_type();
      wr(5'h10, 32'hFFFF_FFFF);
      rd_chk("R4 low type word", 5'h10, 32'h1111_1111);
      wr(5'h18, 32'hFFFF_FFFF);
      rd_chk("R4 high type word", 5'h18, 32'h0000_1111);
      cyc(1);
      rd_chk("R4 active-low latches on low pins", 5'h0C, 32'hFFF);
      wr(5'h10, 32'h0);
      wr(5'h18, 32'h0);
      cyc(1);
      wr(5'h0C, 32'hFFF);
      rd_chk("R4 active-high quiet on low pins", 5'h0C, 32'h0);
   endtask

   task automatic t_w1c();
      pin_in = 12'h088;
      cyc(3);
      pin_in = '0;
      cyc(3);
      rd_chk("R5 two lines latched", 5'h0C, 32'h088);
      wr(5'h0C, 32'h0000_0008);
      rd_chk("R6 zero bits keep status", 5'h0C, 32'h080);
      wr(5'h0C, 32'h0000_0080);
      rd_chk("R6 last bit cleared", 5'h0C, 32'h0);
   endtask

   task automatic t_reack();
      pin_in = 12'h020;
      cyc(3);
      rd_chk("R7 line set", 5'h0C, 32'h020);
      wr(5'h0C, 32'h0000_0020);
      rd_chk("R7 reads 0 after clear", 5'h0C, 32'h0);
      cyc(1);
      rd_chk("R7 re-latched next cycle", 5'h0C, 32'h020);
      pin_in = '0;
      cyc(3);
      wr(5'h0C, 32'hFFF);
   endtask

   task automatic t_mask();
      pin_in = 12'h002;
      cyc(3);
      chk("R8 enable 0 keeps irq low", 32'(irq), 0);
      wr(5'h14, 32'hFFFF_FFFF);
      rd_chk("R10 enable upper bits", 5'h14, 32'h0000_0FFF);
      chk("R8 irq with enable", 32'(irq), 1);
      wr(5'h14, 32'h0000_0001);
      chk("R8 other line enabled only", 32'(irq), 0);
      wr(5'h14, 32'h0000_0002);
      chk("R8 matching line enabled", 32'(irq), 1);
      pin_in = '0;
      cyc(3);
      wr(5'h0C, 32'hFFF);
      chk("R8 irq drops after clear", 32'(irq), 0);
      wr(5'h14, 32'h0);
   endtask

   task automatic t_mux();
      wr(5'h1C, 32'hDEAD_BEEF);
      rd_chk("R9 mux readback", 5'h1C, 32'hDEAD_BEEF);
      chk("R9 mux port", mux_sel, 32'hDEAD_BEEF);
      rd_chk("R10 unmapped address", 5'h01, 32'h0);
      wr(5'h0C, 32'hFFFF_F000);
      rd_chk("R10 status upper bits", 5'h0C, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_outputs();
      t_input_latch();
      t_type();
      t_w1c();
      t_reack();
      t_mask();
      t_mux();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule